// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the I/O register front end of a network controller. The host sees a small window of I/O offsets and reaches two internal banks through it: a control/status bank and a bus-configuration bank. A single 8-bit index register selects the entry in both banks. Two separate data ports read or write the selected control/status word or the selected bus-configuration word. The offsets of the index register and of the configuration data port move with a word/doubleword I/O mode input. The control/status data port stays at the same offset in both modes.

Entry 0 of the control/status bank is the interrupt status word. It holds four error flags that are set by event pulses from elsewhere in the controller, and the host clears them by writing ones. It also holds a read-only summary error bit and a writable stop control bit. One bus-configuration word is also shown to the PCI configuration space as two read-only bytes. These bytes report the controller's minimum burst length and its maximum tolerable arbitration latency. Reads return registered data one cycle after the strobe.

Top module: `indirect_reg_port`

## Requirements
- R1: A write to the index port stores io_wdata[7:0] as the index. A read of the index port returns the index in bits 7:0 and zero in bits 31:8.
- R2: In word mode (io_dword=0) the index port is at offset 12h. In doubleword mode it is at offset 14h. The offset used by the other mode is not decoded in the current mode: reads return zero and writes change nothing.
- R3: The control/status data port is at offset 10h in both modes and reaches control/status entry [index].
- R4: The bus-configuration data port is at offset 16h in word mode and at offset 1Ch in doubleword mode, and reaches bus-configuration entry [index]. It uses the same index as R3.
- R5: The index is cleared by rst and by a soft_rst pulse, and no other state is touched by soft_rst. Writing the stop bit (entry 0, bit 2) reads back and does not change the index.
- R6: Entry 0 holds four error flags: bit 14 babble, bit 13 collision, bit 12 missed frame and bit 11 memory error. Each is set by its event pulse. Writing 1 to a flag clears it and writing 0 leaves it unchanged, so writing back a value just read clears every flag that was set.
- R7: Entry 0 bit 15 reads as the OR of the four flags. Writes to bit 15 have no effect.
- R8: If an event pulse and a write-one-clear of the same flag fall in the same cycle, the flag ends up set.
- R9: A configuration read at 3Eh returns bus-configuration entry 22 bits 7:0, and a read at 3Fh returns bits 15:8. Other configuration offsets return zero. Configuration reads never change any register.
- R10: Control/status indices of 8 or more and bus-configuration indices of 32 or more read as zero, and writes to them are discarded. I/O offsets that match no port read as zero.
- R11: io_rvalid is high, with io_rdata valid, exactly one cycle after a read strobe. io_rdata is zero in every other cycle. cfg_rvalid and cfg_rdata follow the same one-cycle rule.
- R12: After rst, every control/status word is zero and every bus-configuration word is zero, except entry 22, which is FF06h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Software reset pulse, clears the index |
| io_dword | input | 1 | I/O mode: 0 word, 1 doubleword |
| io_req | input | 1 | I/O access strobe, one cycle |
| io_wr | input | 1 | Access direction: 1 write, 0 read |
| io_offset | input | 5 | I/O offset within the window |
| io_wdata | input | 32 | I/O write data |
| io_rdata | output | 32 | Registered I/O read data |
| io_rvalid | output | 1 | Read data valid |
| ev_babl | input | 1 | Babble event pulse |
| ev_cerr | input | 1 | Collision error event pulse |
| ev_miss | input | 1 | Missed frame event pulse |
| ev_merr | input | 1 | Memory error event pulse |
| cfg_rd | input | 1 | Configuration byte read strobe |
| cfg_addr | input | 8 | Configuration space offset |
| cfg_rdata | output | 8 | Registered configuration byte |
| cfg_rvalid | output | 1 | Configuration data valid |

## Verification
The flag update in entry 0 can meet a host write-one-clear of the same flag in one cycle, and the set must win. The bench provokes this by raising an event input on the exact cycle of the status write strobe. It then reads the status word back and expects the flag and the summary bit to still be set. A configuration read of the mirrored word can also coincide with a host write to that word. The cycle-by-cycle model decides the expected byte from the pre-write contents in that case.

// File: rtl/irp_pkg.sv
package irp_pkg;
  typedef enum logic [1:0] {
    PORT_NONE = 2'd0,
    PORT_CSR  = 2'd1,
    PORT_PTR  = 2'd2,
    PORT_BCR  = 2'd3
  } port_e;

  localparam logic [7:0] OFS_CSR   = 8'h10;
  localparam logic [7:0] OFS_PTR_W = 8'h12;
  localparam logic [7:0] OFS_PTR_D = 8'h14;
  localparam logic [7:0] OFS_BCR_W = 8'h16;
  localparam logic [7:0] OFS_BCR_D = 8'h1C;

  localparam logic [7:0] CFG_BURST_OFS = 8'h3E;
  localparam logic [7:0] CFG_LAT_OFS   = 8'h3F;

  localparam int BIT_ERR  = 15;
  localparam int BIT_FHI  = 14;
  localparam int BIT_FLO  = 11;
  localparam int BIT_STOP = 2;
endpackage

// File: rtl/irp_decode.sv
module irp_decode
  import irp_pkg::*;
#(
  parameter int OFSW = 5
) (
  input  logic            dword_mode,
  input  logic [OFSW-1:0] offset,
  output port_e           target
);
  logic [OFSW-1:0] ptr_ofs;
  logic [OFSW-1:0] bcr_ofs;

  assign ptr_ofs = dword_mode ? OFSW'(OFS_PTR_D) : OFSW'(OFS_PTR_W);
  assign bcr_ofs = dword_mode ? OFSW'(OFS_BCR_D) : OFSW'(OFS_BCR_W);

  always_comb begin
    target = PORT_NONE;
    if (offset == OFSW'(OFS_CSR))  target = PORT_CSR;
    else if (offset == ptr_ofs)    target = PORT_PTR;
    else if (offset == bcr_ofs)    target = PORT_BCR;
  end
endmodule

// File: rtl/irp_csr_bank.sv
module irp_csr_bank
  import irp_pkg::*;
#(
  parameter int DW        = 16,
  parameter int IDXW      = 8,
  parameter int CSR_COUNT = 8,
  parameter int NFLAG     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IDXW-1:0] idx,
  input  logic [DW-1:0]   wdata,
  input  logic [NFLAG-1:0] ev,
  output logic [DW-1:0]   rdata
);
  localparam int CW = (CSR_COUNT > 1) ? $clog2(CSR_COUNT) : 1;

  logic [DW-1:0]    mem [CSR_COUNT];
  logic [NFLAG-1:0] flags_q;
  logic             stop_q;
  logic             hit0;
  logic             in_range;
  logic [NFLAG-1:0] clr_mask;
  logic [DW-1:0]    status_v;

  assign hit0     = (idx == '0);
  assign in_range = int'(idx) < CSR_COUNT;
  assign clr_mask = (wr_en && hit0) ? wdata[BIT_FHI:BIT_FLO] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      stop_q  <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr_mask) | ev;
      if (wr_en && hit0) stop_q <= wdata[BIT_STOP];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CSR_COUNT; i++) mem[i] <= '0;
    end else if (wr_en && !hit0 && in_range) begin
      mem[idx[CW-1:0]] <= wdata;
    end
  end

  always_comb begin
    status_v                  = '0;
    status_v[BIT_ERR]         = |flags_q;
    status_v[BIT_FHI:BIT_FLO] = flags_q;
    status_v[BIT_STOP]        = stop_q;
  end

  always_comb begin
    if (hit0)          rdata = status_v;
    else if (in_range) rdata = mem[idx[CW-1:0]];
    else               rdata = '0;
  end

  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    ev[NFLAG-1] |=> status_v[BIT_FHI]);

  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit0 && wdata[BIT_FHI] && !ev[NFLAG-1]) |=> !status_v[BIT_FHI]);

  a_r7_summary_follows: assert property (@(posedge clk) disable iff (rst)
    (|ev) |=> status_v[BIT_ERR]);

  a_r6_zero_keeps: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit0 && !wdata[BIT_FLO] && status_v[BIT_FLO]) |=> status_v[BIT_FLO]);
endmodule

// File: rtl/irp_bcr_bank.sv
module irp_bcr_bank #(
  parameter int          DW         = 16,
  parameter int          IDXW       = 8,
  parameter int          BCR_COUNT  = 32,
  parameter int          MM_IDX     = 22,
  parameter logic [15:0] MM_DEFAULT = 16'hFF06
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IDXW-1:0] idx,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [DW-1:0]   mm_word
);
  localparam int BW = (BCR_COUNT > 1) ? $clog2(BCR_COUNT) : 1;

  logic [DW-1:0] mem [BCR_COUNT];
  logic          in_range;

  assign in_range = int'(idx) < BCR_COUNT;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < BCR_COUNT; i++)
        mem[i] <= (i == MM_IDX) ? DW'(MM_DEFAULT) : '0;
    end else if (wr_en && in_range) begin
      mem[idx[BW-1:0]] <= wdata;
    end
  end

  assign rdata   = in_range ? mem[idx[BW-1:0]] : '0;
  assign mm_word = mem[MM_IDX];

  a_r9_mirror_only_own_write: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && int'(idx) == MM_IDX) |=> $stable(mm_word));
endmodule

// File: rtl/indirect_reg_port.sv
module indirect_reg_port
  import irp_pkg::*;
#(
  parameter int          OFSW       = 5,
  parameter int          IOW        = 32,
  parameter int          DW         = 16,
  parameter int          IDXW       = 8,
  parameter int          CSR_COUNT  = 8,
  parameter int          BCR_COUNT  = 32,
  parameter int          MM_IDX     = 22,
  parameter logic [15:0] MM_DEFAULT = 16'hFF06,
  parameter int          CFGW       = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            soft_rst,
  input  logic            io_dword,
  input  logic            io_req,
  input  logic            io_wr,
  input  logic [OFSW-1:0] io_offset,
  input  logic [IOW-1:0]  io_wdata,
  output logic [IOW-1:0]  io_rdata,
  output logic            io_rvalid,
  input  logic            ev_babl,
  input  logic            ev_cerr,
  input  logic            ev_miss,
  input  logic            ev_merr,
  input  logic            cfg_rd,
  input  logic [CFGW-1:0] cfg_addr,
  output logic [CFGW-1:0] cfg_rdata,
  output logic            cfg_rvalid
);
  localparam int NFLAG = 4;

  port_e           target;
  logic [IDXW-1:0] ptr_q;
  logic            is_rd;
  logic            is_wr;
  logic            csr_wr;
  logic            bcr_wr;
  logic [DW-1:0]   csr_rdata;
  logic [DW-1:0]   bcr_rdata;
  logic [DW-1:0]   mm_word;
  logic [IOW-1:0]  rd_mux;
  logic [CFGW-1:0] cfg_mux;
  logic [NFLAG-1:0] ev_vec;

  assign is_rd  = io_req && !io_wr;
  assign is_wr  = io_req && io_wr;
  assign csr_wr = is_wr && (target == PORT_CSR);
  assign bcr_wr = is_wr && (target == PORT_BCR);
  assign ev_vec = {ev_babl, ev_cerr, ev_miss, ev_merr};

  irp_decode #(.OFSW(OFSW)) u_decode (
    .dword_mode (io_dword),
    .offset     (io_offset),
    .target     (target)
  );

  irp_csr_bank #(
    .DW(DW), .IDXW(IDXW), .CSR_COUNT(CSR_COUNT), .NFLAG(NFLAG)
  ) u_csr (
    .clk   (clk),
    .rst   (rst),
    .wr_en (csr_wr),
    .idx   (ptr_q),
    .wdata (io_wdata[DW-1:0]),
    .ev    (ev_vec),
    .rdata (csr_rdata)
  );

  irp_bcr_bank #(
    .DW(DW), .IDXW(IDXW), .BCR_COUNT(BCR_COUNT),
    .MM_IDX(MM_IDX), .MM_DEFAULT(MM_DEFAULT)
  ) u_bcr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bcr_wr),
    .idx     (ptr_q),
    .wdata   (io_wdata[DW-1:0]),
    .rdata   (bcr_rdata),
    .mm_word (mm_word)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_rst)                   ptr_q <= '0;
    else if (is_wr && target == PORT_PTR)  ptr_q <= io_wdata[IDXW-1:0];
  end

  always_comb begin
    unique case (target)
      PORT_CSR: rd_mux = IOW'(csr_rdata);
      PORT_PTR: rd_mux = IOW'(ptr_q);
      PORT_BCR: rd_mux = IOW'(bcr_rdata);
      default:  rd_mux = '0;
    endcase
  end

  always_comb begin
    if (cfg_addr == CFGW'(CFG_BURST_OFS))    cfg_mux = mm_word[7:0];
    else if (cfg_addr == CFGW'(CFG_LAT_OFS)) cfg_mux = mm_word[15:8];
    else                                     cfg_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata   <= '0;
      io_rvalid  <= 1'b0;
      cfg_rdata  <= '0;
      cfg_rvalid <= 1'b0;
    end else begin
      io_rvalid  <= is_rd;
      io_rdata   <= is_rd ? rd_mux : '0;
      cfg_rvalid <= cfg_rd;
      cfg_rdata  <= cfg_rd ? cfg_mux : '0;
    end
  end

  a_r5_soft_clears_index: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (ptr_q == '0));

  a_r2_foreign_offset_inert: assert property (@(posedge clk) disable iff (rst)
    (io_req && !io_dword && io_offset == OFSW'(OFS_PTR_D) && !soft_rst) |=> $stable(ptr_q));

  a_r11_read_one_cycle: assert property (@(posedge clk) disable iff (rst)
    is_rd |=> io_rvalid);

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !is_rd |=> (!io_rvalid && io_rdata == '0));
endmodule

// File: tb/indirect_reg_port_test.sv
`timescale 1ns/1ps
module indirect_reg_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic        io_dword = 1'b0;
  logic        io_req = 1'b0;
  logic        io_wr = 1'b0;
  logic [4:0]  io_offset = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        io_rvalid;
  logic        ev_babl = 1'b0, ev_cerr = 1'b0, ev_miss = 1'b0, ev_merr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_rdata;
  logic        cfg_rvalid;

  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R12";
  bit    started = 0;

  always #4 clk = ~clk;

  indirect_reg_port uut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .io_dword(io_dword),
    .io_req(io_req), .io_wr(io_wr), .io_offset(io_offset), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .ev_babl(ev_babl), .ev_cerr(ev_cerr), .ev_miss(ev_miss), .ev_merr(ev_merr),
    .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid)
  );

  // behavioural reference model
  int          m_ptr;
  int          m_csr [8];
  int          m_bcr [32];
  logic [3:0]  m_flags;
  logic        m_stop;
  logic [31:0] exp_rdata;
  logic        exp_rvalid;
  logic [7:0]  exp_cfg;
  logic        exp_cfgv;

  function automatic int port_of(logic dw, logic [4:0] ofs);
    if (ofs == 5'h10) return 1;
    if (!dw && ofs == 5'h12) return 2;
    if (dw && ofs == 5'h14) return 2;
    if (!dw && ofs == 5'h16) return 3;
    if (dw && ofs == 5'h1C) return 3;
    return 0;
  endfunction

  function automatic int read_val(int p);
    if (p == 2) return m_ptr;
    if (p == 1) begin
      if (m_ptr == 0) return int'({|m_flags, m_flags, 8'b0, m_stop, 2'b0});
      if (m_ptr < 8) return m_csr[m_ptr];
      return 0;
    end
    if (p == 3) return (m_ptr < 32) ? m_bcr[m_ptr] : 0;
    return 0;
  endfunction

  always @(posedge clk) begin : model
    int p;
    logic [3:0] clr;
    started = 1;
    if (rst) begin
      m_ptr = 0; m_flags = '0; m_stop = 1'b0;
      foreach (m_csr[i]) m_csr[i] = 0;
      foreach (m_bcr[i]) m_bcr[i] = 0;
      m_bcr[22] = 32'hFF06;
      exp_rdata = '0; exp_rvalid = 1'b0; exp_cfg = '0; exp_cfgv = 1'b0;
    end else begin
      p = port_of(io_dword, io_offset);
      exp_rvalid = io_req && !io_wr;
      exp_rdata  = exp_rvalid ? 32'(read_val(p)) : '0;
      exp_cfgv   = cfg_rd;
      if (!cfg_rd) exp_cfg = '0;
      else if (cfg_addr == 8'h3E) exp_cfg = 8'(m_bcr[22] & 255);
      else if (cfg_addr == 8'h3F) exp_cfg = 8'((m_bcr[22] >> 8) & 255);
      else exp_cfg = '0;
      clr = '0;
      if (io_req && io_wr) begin
        if (p == 1) begin
          if (m_ptr == 0) begin clr = io_wdata[14:11]; m_stop = io_wdata[2]; end
          else if (m_ptr < 8) m_csr[m_ptr] = int'(io_wdata[15:0]);
        end else if (p == 3) begin
          if (m_ptr < 32) m_bcr[m_ptr] = int'(io_wdata[15:0]);
        end else if (p == 2) begin
          m_ptr = int'(io_wdata[7:0]);
        end
      end
      m_flags = (m_flags & ~clr) | {ev_babl, ev_cerr, ev_miss, ev_merr};
      if (soft_rst) m_ptr = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk({cur_tag, " R11 io_rvalid"}, 32'(io_rvalid), 32'(exp_rvalid));
      chk({cur_tag, " io_rdata"}, io_rdata, exp_rdata);
      chk({cur_tag, " R11 cfg_rvalid"}, 32'(cfg_rvalid), 32'(exp_cfgv));
      chk({cur_tag, " cfg_rdata"}, 32'(cfg_rdata), 32'(exp_cfg));
    end
  end

  task automatic io_write(logic [4:0] ofs, logic [31:0] d, logic [3:0] ev = 4'b0);
    @(negedge clk);
    io_req = 1; io_wr = 1; io_offset = ofs; io_wdata = d;
    {ev_babl, ev_cerr, ev_miss, ev_merr} = ev;
    @(negedge clk);
    io_req = 0; io_wr = 0;
    {ev_babl, ev_cerr, ev_miss, ev_merr} = 4'b0;
  endtask

  task automatic io_read(logic [4:0] ofs, output logic [31:0] d);
    @(negedge clk);
    io_req = 1; io_wr = 0; io_offset = ofs;
    @(negedge clk);
    io_req = 0;
    d = io_rdata;
  endtask

  task automatic cfg_read(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_rd = 1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 0;
    d = cfg_rdata;
  endtask

  task automatic pulse_ev(logic [3:0] ev);
    @(negedge clk);
    {ev_babl, ev_cerr, ev_miss, ev_merr} = ev;
    @(negedge clk);
    {ev_babl, ev_cerr, ev_miss, ev_merr} = 4'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  c;
    repeat (3) @(negedge clk);
    rst = 0;

    cur_tag = "R12";
    cfg_read(8'h3E, c); chk("R12 R9 min burst default", 32'(c), 32'h06);
    cfg_read(8'h3F, c); chk("R12 R9 max latency default", 32'(c), 32'hFF);
    io_read(5'h10, r);  chk("R12 status zero", r, 32'h0);

    cur_tag = "R1";
    io_write(5'h12, 32'hFFFF_AB05);
    io_read(5'h12, r);  chk("R1 index readback", r, 32'h05);

    cur_tag = "R3";
    io_write(5'h10, 32'h0000_1234);
    io_read(5'h10, r);  chk("R3 csr5 readback", r, 32'h1234);

    cur_tag = "R4";
    io_write(5'h16, 32'h0000_BEEF);
    io_read(5'h16, r);  chk("R4 bcr5 readback", r, 32'hBEEF);
    io_read(5'h10, r);  chk("R4 csr5 unaffected", r, 32'h1234);

    cur_tag = "R2";
    io_dword = 1;
    io_write(5'h14, 32'h3);
    io_write(5'h12, 32'h7);
    io_read(5'h14, r);  chk("R2 dword index kept", r, 32'h3);
    io_read(5'h12, r);  chk("R2 word offset inert", r, 32'h0);
    io_write(5'h1C, 32'h0000_5A5A);
    io_read(5'h1C, r);  chk("R2 R4 dword bcr3", r, 32'h5A5A);
    io_dword = 0;
    io_read(5'h16, r);  chk("R4 word bcr3", r, 32'h5A5A);
    io_write(5'h14, 32'h9);
    io_read(5'h12, r);  chk("R2 dword offset inert in word", r, 32'h3);

    cur_tag = "R10";
    io_write(5'h12, 32'h40);
    io_write(5'h10, 32'hFFFF);
    io_write(5'h16, 32'hFFFF);
    io_read(5'h10, r);  chk("R10 csr oob", r, 32'h0);
    io_read(5'h16, r);  chk("R10 bcr oob", r, 32'h0);
    io_read(5'h18, r);  chk("R10 no port", r, 32'h0);

    cur_tag = "R6";
    io_write(5'h12, 32'h0);
    pulse_ev(4'b1010);
    io_read(5'h10, r);  chk("R6 R7 flags set", r, 32'hD000);
    io_write(5'h10, r);
    io_read(5'h10, r);  chk("R6 writeback clears", r, 32'h0);
    pulse_ev(4'b0100);
    io_write(5'h10, 32'h0);
    io_read(5'h10, r);  chk("R6 zero write keeps", r, 32'hA000);

    cur_tag = "R7";
    io_write(5'h10, 32'h2000);
    io_write(5'h10, 32'h8000);
    io_read(5'h10, r);  chk("R7 summary write ignored", r, 32'h0);

    cur_tag = "R8";
    io_write(5'h10, 32'h0800, 4'b0001);
    io_read(5'h10, r);  chk("R8 set beats clear", r, 32'h8800);
    io_write(5'h10, 32'h0800);

    cur_tag = "R5";
    io_write(5'h10, 32'h0004);
    io_read(5'h12, r);  chk("R5 stop keeps index", r, 32'h0);
    io_read(5'h10, r);  chk("R5 stop readback", r, 32'h0004);
    io_write(5'h12, 32'h9);
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    io_read(5'h12, r);  chk("R5 soft reset clears index", r, 32'h0);
    io_read(5'h10, r);  chk("R5 soft reset keeps stop", r, 32'h0004);

    cur_tag = "R9";
    io_write(5'h12, 32'd22);
    io_write(5'h16, 32'h3C11);
    cfg_read(8'h3E, c); chk("R9 low byte", 32'(c), 32'h11);
    cfg_read(8'h3F, c); chk("R9 high byte", 32'(c), 32'h3C);
    cfg_read(8'h40, c); chk("R9 other cfg offset", 32'(c), 32'h0);
    io_read(5'h16, r);  chk("R9 cfg read no side effect", r, 32'h3C11);

    cur_tag = "R12";
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    io_read(5'h12, r);  chk("R12 R5 index after reset", r, 32'h0);
    cfg_read(8'h3F, c); chk("R12 mirror restored", 32'(c), 32'hFF);
    io_write(5'h12, 32'h5);
    io_read(5'h10, r);  chk("R12 csr5 cleared", r, 32'h0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule